// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block produces two groups of gated clock outputs, a CPU group and a PCI group, plus one free-running PCI clock. All of them are derived from a single fast reference clock. Each output is modelled as a registered square wave whose phase comes from a shared frame counter. The PCI clocks run at a fixed third or half of the CPU rate. Their rising edges always fall on a CPU rising edge.

Three active-low controls decide which outputs run: a CPU stop, a PCI stop and a power-down. Every control passes through a two-flop synchronizer first. An enable changes only at the instant its clock would start a new high phase. As a result, a stopped output parks low after a complete high phase, and a restarted output begins with a complete high phase. Several other rules apply:

- The PCI stop is captured on a rising edge of the free-running PCI clock and applied one cycle later.
- Power-down stops every output, including the free-running one.
- Leaving power-down waits a parameterized number of reference cycles before the outputs start again.
- One select code requests high impedance. This is reported on an output-enable pin for the pad ring.

Top module: `clkstop_ctrl`

## Requirements
- R1: With `sel_code[2]`=1 the CPU outputs have a period of 2*HALF_HI reference cycles (4 at defaults). With `sel_code[2]`=0 the period is 2*HALF_LO (6). The PCI outputs and `pci_free` always have a period of 2*HALF_HI*HALF_LO (12). All lanes of a group carry identical values.
- R2: While the CPU group and `pci_free` both run, every rising edge of `pci_free` occurs in the same reference cycle as a rising edge of the CPU outputs.
- R3: After `cpu_stop_n` goes low, the CPU outputs produce no more than three further rising edges. They end their current high phase and then stay low.
- R4: After `cpu_stop_n` returns high, the CPU outputs rise again within three CPU periods, and their first high phase is full length.
- R5: `pci_stop_n` is synchronized and then captured on a rising edge of `pci_free`. The captured value gates the gated PCI outputs from the next `pci_free` cycle onward. If the pin falls just after a `pci_free` rising edge, exactly one more rising edge appears on the gated PCI outputs. `pci_free` is never affected by `pci_stop_n`.
- R6: While `pwr_dwn_n` is low, all twelve clock outputs settle low after finishing their current high phase.
- R7: After `pwr_dwn_n` returns high, the outputs stay low for at least PD_EXIT_CYCLES reference cycles. The CPU outputs and `pci_free` then resume within PD_EXIT_CYCLES+16 reference cycles of the pin change.
- R8: `sel_code`=3'b000 drives `drive_en` low one cycle later. In that mode the clocks keep toggling at the low-speed rate. Every other code drives `drive_en` high.
- R9: For any timing of the stop inputs, every high pulse on every output lasts exactly one full high phase: 2 or 3 reference cycles for CPU lanes (by `sel_code[2]`) and 6 for PCI lanes.
- R10: During reset all clock outputs and `drive_en` are low. After reset, no output rises for at least PD_EXIT_CYCLES reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low stop for the CPU group |
| pci_stop_n | input | 1 | Active-low stop for the gated PCI group |
| pwr_dwn_n | input | 1 | Active-low power-down for all outputs |
| sel_code | input | 3 | Bit 2 selects the high CPU rate; 3'b000 requests high impedance |
| cpu_clk | output | CPU_LANES | Gated CPU clocks |
| pci_clk | output | PCI_LANES | Gated PCI clocks |
| pci_free | output | 1 | Free-running PCI clock (power-down only) |
| drive_en | output | 1 | Pad output enable, low in high-impedance mode |

## Verification
The bench toggles the stop inputs at random offsets relative to the clock phases. It measures every high pulse on every lane. A design that applies an enable mid-phase would show a truncated pulse of one or two cycles. The PCI stop is dropped right after a free-running edge, and the bench counts exactly one further gated edge. A design that applies the sample at once would show none, and one without the capture stage could show two. Power-down exit is timed against the parameterized wait, which catches a counter that ends early or never releases. Each select code is measured by counting edges in a fixed window, which exposes a wrong divider or a misaligned PCI edge.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  typedef logic [2:0] sel_t;

  // select code that floats every clock pin
  localparam sel_t SEL_HIZ = 3'b000;
  // bit of the select code that picks the fast CPU rate
  localparam int SEL_SPEED_BIT = 2;

  // synchronized control bundle
  typedef struct packed {
    logic cpu_run_n;
    logic pci_run_n;
    logic pwr_up_n;
  } ctl_t;

  function automatic logic is_hiz(input sel_t s);
    return s == SEL_HIZ;
  endfunction
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/clkstop_phase.sv
module clkstop_phase #(
  parameter int HALF_HI = 2,
  parameter int HALF_LO = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_hi,
  output logic cpu_ph,
  output logic cpu_ph_nx,
  output logic pci_ph,
  output logic pci_ph_nx
);
  localparam int PCI_HALF = HALF_HI * HALF_LO;
  localparam int FRAME    = 2 * PCI_HALF;
  localparam int FW       = $clog2(FRAME);

  logic [FW-1:0] frame_q, frame_nx;
  logic          hi_ph_nx, lo_ph_nx;

  // one frame holds a whole number of CPU periods at either rate
  assign frame_nx  = (frame_q == FW'(FRAME - 1)) ? '0 : frame_q + 1'b1;
  assign hi_ph_nx  = (frame_nx % FW'(2 * HALF_HI)) < FW'(HALF_HI);
  assign lo_ph_nx  = (frame_nx % FW'(2 * HALF_LO)) < FW'(HALF_LO);
  assign cpu_ph_nx = speed_hi ? hi_ph_nx : lo_ph_nx;
  assign pci_ph_nx = frame_nx < FW'(PCI_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= FW'(FRAME - 1);
      cpu_ph  <= 1'b0;
      pci_ph  <= 1'b0;
    end else begin
      frame_q <= frame_nx;
      cpu_ph  <= cpu_ph_nx;
      pci_ph  <= pci_ph_nx;
    end
  end

  // R2
  pci_cpu_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_ph) |-> $rose(cpu_ph));
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph,
  input  logic             ph_nx,
  input  logic             want,
  output logic [LANES-1:0] clk_out
);
  logic rise_nx;

  // the only edge at which a lane may change its enable
  assign rise_nx = ph_nx & ~ph;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic en_q;
    logic out_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q  <= 1'b0;
        out_q <= 1'b0;
      end else begin
        if (rise_nx) en_q <= want;
        out_q <= ph_nx & (rise_nx ? want : en_q);
      end
    end

    assign clk_out[i] = out_q;

    // R9
    lane_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_q |-> ph);
    // R9
    en_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(en_q) |-> $rose(ph));
  end
endmodule

// File: rtl/clkstop_pdexit.sv
module clkstop_pdexit #(
  parameter int EXIT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_up,
  output logic hold
);
  localparam int CW = $clog2(EXIT_CYCLES + 1);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      hold   <= 1'b1;
    end else if (!pwr_up) begin
      wait_q <= '0;
      hold   <= 1'b1;
    end else if (wait_q != CW'(EXIT_CYCLES)) begin
      wait_q <= wait_q + 1'b1;
    end else begin
      hold   <= 1'b0;
    end
  end

  // R6
  pd_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_up |=> hold);
  // R7
  pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(pwr_up));
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int CPU_LANES      = 4,
  parameter int PCI_LANES      = 7,
  parameter int HALF_HI        = 2,
  parameter int HALF_LO        = 3,
  parameter int PD_EXIT_CYCLES = 64
) (
  input  logic                 clk_ref,
  input  logic                 rst_n,
  input  logic                 cpu_stop_n,
  input  logic                 pci_stop_n,
  input  logic                 pwr_dwn_n,
  input  logic [2:0]           sel_code,
  output logic [CPU_LANES-1:0] cpu_clk,
  output logic [PCI_LANES-1:0] pci_clk,
  output logic                 pci_free,
  output logic                 drive_en
);
  ctl_t ctl_raw, ctl_s;
  logic cpu_ph, cpu_ph_nx, pci_ph, pci_ph_nx;
  logic pd_hold, pci_samp, pci_rise_nx;
  logic cpu_want, pci_want, free_want;

  assign ctl_raw = '{cpu_run_n: cpu_stop_n, pci_run_n: pci_stop_n, pwr_up_n: pwr_dwn_n};

  clkstop_sync #(.W($bits(ctl_t)), .RST_VAL('0)) u_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  clkstop_phase #(.HALF_HI(HALF_HI), .HALF_LO(HALF_LO)) u_phase (
    .clk(clk_ref), .rst_n(rst_n), .speed_hi(sel_code[SEL_SPEED_BIT]),
    .cpu_ph(cpu_ph), .cpu_ph_nx(cpu_ph_nx), .pci_ph(pci_ph), .pci_ph_nx(pci_ph_nx)
  );

  clkstop_pdexit #(.EXIT_CYCLES(PD_EXIT_CYCLES)) u_pdexit (
    .clk(clk_ref), .rst_n(rst_n), .pwr_up(ctl_s.pwr_up_n), .hold(pd_hold)
  );

  // PCI stop is captured on free-running PCI rising edges only
  assign pci_rise_nx = pci_ph_nx & ~pci_ph;

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pci_samp <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      if (pci_rise_nx) pci_samp <= ctl_s.pci_run_n;
      drive_en <= !is_hiz(sel_code);
    end
  end

  assign cpu_want  = ctl_s.cpu_run_n & ~pd_hold;
  assign pci_want  = pci_samp & ~pd_hold;
  assign free_want = ~pd_hold;

  clkstop_gate #(.LANES(CPU_LANES)) u_cpu_gate (
    .clk(clk_ref), .rst_n(rst_n), .ph(cpu_ph), .ph_nx(cpu_ph_nx),
    .want(cpu_want), .clk_out(cpu_clk)
  );

  clkstop_gate #(.LANES(PCI_LANES)) u_pci_gate (
    .clk(clk_ref), .rst_n(rst_n), .ph(pci_ph), .ph_nx(pci_ph_nx),
    .want(pci_want), .clk_out(pci_clk)
  );

  clkstop_gate #(.LANES(1)) u_free_gate (
    .clk(clk_ref), .rst_n(rst_n), .ph(pci_ph), .ph_nx(pci_ph_nx),
    .want(free_want), .clk_out(pci_free)
  );

  // R8
  hiz_release_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    is_hiz($past(sel_code)) |-> !drive_en);
  // R6
  pd_free_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(pci_free) |-> !$past(pd_hold));
  // R3
  cpu_stop_start_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(cpu_clk[0]) |-> $past(ctl_s.cpu_run_n));
  // R5
  pci_stop_start_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(pci_clk[0]) |-> $past(pci_samp));
endmodule

// File: tb/sim_clkstop_ctrl.sv
module sim_clkstop_ctrl;
  localparam int PD_EXIT = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_stop_n = 1'b1;
  logic       pci_stop_n = 1'b1;
  logic       pwr_dwn_n = 1'b1;
  logic [2:0] sel = 3'b100;
  logic [3:0] cpu_clk;
  logic [6:0] pci_clk;
  logic       pci_free;
  logic       drive_en;

  int  tests = 0;
  int  failed = 0;
  int  pulses_seen = 0;
  bit  align_on = 1'b0;
  bit  done = 1'b0;

  clkstop_ctrl #(.PD_EXIT_CYCLES(PD_EXIT)) u0 (
    .clk_ref(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pwr_dwn_n(pwr_dwn_n), .sel_code(sel), .cpu_clk(cpu_clk), .pci_clk(pci_clk),
    .pci_free(pci_free), .drive_en(drive_en)
  );

  always #2 clk = ~clk;

  // vector: cpu_n pci_n pd_n sel[2:0] | cpu rises, pci rises, free rises (per 120 cycles), oe
  localparam logic [22:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b1, 3'b100, 8'd30, 4'd10, 4'd10, 1'b1},
    {1'b1, 1'b1, 1'b1, 3'b001, 8'd20, 4'd10, 4'd10, 1'b1},
    {1'b0, 1'b1, 1'b1, 3'b100, 8'd0,  4'd10, 4'd10, 1'b1},
    {1'b1, 1'b0, 1'b1, 3'b100, 8'd30, 4'd0,  4'd10, 1'b1},
    {1'b0, 1'b0, 1'b1, 3'b001, 8'd0,  4'd0,  4'd10, 1'b1},
    {1'b1, 1'b1, 1'b0, 3'b100, 8'd0,  4'd0,  4'd0,  1'b1},
    {1'b1, 1'b1, 1'b1, 3'b000, 8'd20, 4'd10, 4'd10, 1'b0},
    {1'b1, 1'b1, 1'b1, 3'b111, 8'd30, 4'd10, 4'd10, 1'b1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse-width (R9) and edge-alignment (R2) monitor
  int         run_len [12];
  logic [11:0] prev_v = '0;
  always @(negedge clk) begin
    logic [11:0] v;
    int exp_len;
    v = {pci_free, pci_clk, cpu_clk};
    if (!rst_n) begin
      prev_v = '0;
      for (int i = 0; i < 12; i++) run_len[i] = 0;
    end else begin
      for (int i = 0; i < 12; i++) begin
        if (v[i]) run_len[i]++;
        else if (prev_v[i]) begin
          exp_len = (i < 4) ? (sel[2] ? 2 : 3) : 6;
          pulses_seen++;
          if (run_len[i] != exp_len) begin
            tests++; failed++;
            $display("FAIL R9 pulse on output %0d: actual %0d expected %0d", i, run_len[i], exp_len);
          end
          run_len[i] = 0;
        end
      end
      if (align_on && v[11] && !prev_v[11]) begin
        tests++;
        if (!(v[0] && !prev_v[0])) begin
          failed++;
          $display("FAIL R2 PCI edge without CPU edge: actual %0d expected %0d", v[0], 1);
        end
      end
      prev_v = v;
    end
  end

  task automatic measure(input int n, output int cr, output int pr, output int fr,
                         output int lane_bad);
    logic pc, pp, pf;
    cr = 0; pr = 0; fr = 0; lane_bad = 0;
    @(negedge clk);
    pc = cpu_clk[0]; pp = pci_clk[0]; pf = pci_free;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cpu_clk[0] && !pc) cr++;
      if (pci_clk[0] && !pp) pr++;
      if (pci_free && !pf) fr++;
      if ((cpu_clk != '0 && cpu_clk != '1) || (pci_clk != '0 && pci_clk != '1)) lane_bad++;
      pc = cpu_clk[0]; pp = pci_clk[0]; pf = pci_free;
    end
  endtask

  task automatic set_mode(input logic [2:0] s);
    pwr_dwn_n = 1'b0;
    tick(30);
    sel = s;
    pwr_dwn_n = 1'b1;
    tick(PD_EXIT + 40);
  endtask

  task automatic cpu_stop_test(input logic [2:0] s, input int per);
    int cr, k;
    logic pc;
    set_mode(s);
    cpu_stop_n = 1'b0;
    cr = 0; pc = cpu_clk[0];
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cpu_clk[0] && !pc) cr++;
      pc = cpu_clk[0];
    end
    check(cr <= 3, "R3", "CPU edges after stop", cr, 3);
    check(cpu_clk == '0, "R3", "CPU parked low", cpu_clk, 0);
    cpu_stop_n = 1'b1;
    k = 0;
    while (!cpu_clk[0] && k < 100) begin @(negedge clk); k++; end
    check(k <= 3 * per, "R4", "CPU restart delay", k, 3 * per);
    tick(20);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    int cr, pr, fr, lb, k, kf;
    logic pf;

    // R10 reset state
    tick(8);
    check(cpu_clk == '0 && pci_clk == '0 && !pci_free, "R10", "outputs in reset",
          {cpu_clk, pci_clk, pci_free}, 0);
    check(!drive_en, "R10", "drive_en in reset", drive_en, 0);
    rst_n = 1'b1;
    k = 0;
    while (!cpu_clk[0] && k < 400) begin @(negedge clk); k++; end
    check(k >= PD_EXIT, "R10", "first edge after reset", k, PD_EXIT);
    tick(40);

    // vector table
    for (int i = 0; i < 8; i++) begin
      logic [22:0] e;
      e = VEC[i];
      pwr_dwn_n = 1'b0;
      tick(30);
      cpu_stop_n = e[22];
      pci_stop_n = e[21];
      sel = e[19:17];
      pwr_dwn_n = e[20];
      tick(250);
      align_on = (e[16:9] != 0) && (e[4:1] != 0);
      measure(120, cr, pr, fr, lb);
      align_on = 1'b0;
      check(cr == int'(e[16:9]), "R1", "CPU edge count", cr, e[16:9]);
      check(pr == int'(e[8:5]), "R5", "gated PCI edge count", pr, e[8:5]);
      check(fr == int'(e[4:1]), "R6", "free PCI edge count", fr, e[4:1]);
      check(drive_en == e[0], "R8", "drive_en", drive_en, e[0]);
      check(lb == 0, "R1", "lanes differ", lb, 0);
    end
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1;

    // CPU stop/restart at both rates
    cpu_stop_test(3'b100, 4);
    cpu_stop_test(3'b001, 6);

    // R5: capture on free edge, effect one cycle later
    set_mode(3'b100);
    pf = pci_free;
    while (!(pci_free && !pf)) begin pf = pci_free; @(negedge clk); end
    pci_stop_n = 1'b0;
    measure(59, cr, pr, fr, lb);
    check(pr == 1, "R5", "gated edges after stop", pr, 1);
    check(fr == 5, "R5", "free edges during stop", fr, 5);
    pci_stop_n = 1'b1;
    tick(40);

    // R6/R7 power-down entry and exit
    pwr_dwn_n = 1'b0;
    tick(30);
    measure(24, cr, pr, fr, lb);
    check(cr + pr + fr == 0, "R6", "edges in power-down", cr + pr + fr, 0);
    check({cpu_clk, pci_clk, pci_free} == '0, "R6", "outputs in power-down",
          {cpu_clk, pci_clk, pci_free}, 0);
    pwr_dwn_n = 1'b1;
    k = -1; kf = -1;
    for (int i = 1; i <= PD_EXIT + 40; i++) begin
      @(negedge clk);
      if (k < 0 && cpu_clk[0]) k = i;
      if (kf < 0 && pci_free) kf = i;
    end
    check(k >= PD_EXIT && k <= PD_EXIT + 16, "R7", "CPU resume delay", k, PD_EXIT);
    check(kf >= PD_EXIT && kf <= PD_EXIT + 16, "R7", "free PCI resume delay", kf, PD_EXIT);

    // R9 random stop timing at both rates
    for (int m = 0; m < 2; m++) begin
      set_mode(m == 0 ? 3'b100 : 3'b001);
      for (int i = 0; i < 60; i++) begin
        tick($urandom_range(1, 25));
        if ($urandom_range(0, 1) == 1) cpu_stop_n = ~cpu_stop_n;
        else pci_stop_n = ~pci_stop_n;
      end
      cpu_stop_n = 1'b1; pci_stop_n = 1'b1;
      tick(60);
    end
    check(pulses_seen > 100, "R9", "pulses observed", pulses_seen, 100);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule